// File: doc/BRIEF.md
# Byte-Serial Peripheral Port with Master Loss Detection

This block is a byte-wide SPI peripheral reached through a small register file: control, status and data. Software picks master or slave through a control bit. As master the block produces the serial clock from the system clock through a selectable divider. Each byte written to the data register goes out MSB first while a byte comes back in the same eight clocks. As slave it follows an external clock, and only while its select input is low.

The transmit side holds one byte, the shift register itself. The receive side keeps a separate buffer that takes each finished byte. A completion flag, with an enable bit, drives the interrupt output. Contention on a shared bus is covered by mode-fault detection. If the select input is treated as an input while in master mode and it goes low, the block gives up master mode, releases its driven pins and raises the flag.

Register map (addr): 0 control, 1 status, 2 data. Control bits: 0 enable, 1 master, 2 interrupt enable, 4:3 divider select, 5 select pin is an output. Status bits: 7 transfer done, 6 write collision.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset, control and status read 0, irq is 0, sckOe, mosiOe and misoOe are 0, and sckOut is 0.
- R2: In master mode (control 1:0 = 2'b11), a data write while idle sends eight SPI mode 0 clock pulses. The byte goes out MSB first on mosiOut, and the byte sampled from misoIn on rising edges is received.
- R3: Divider select d (control 4:3) gives a half period of 2^d system clocks. The done flag is set 16*2^d cycles after the clock edge that takes the data write.
- R4: A data write during a transfer does not alter the byte being shifted, and it sets the collision flag (status bit 6).
- R5: At completion the received byte goes to the receive buffer, which a data read returns. An unread byte is overwritten by the next completed transfer.
- R6: Completion sets status bit 7. irq is high exactly while status bit 7 and control bit 2 are both 1.
- R7: Status bits 7 and 6 clear only on a data access that follows a status read made while one of them was set. A data access with no such read leaves them set.
- R8: With enable, master and control bit 5 = 0, a low select input clears control bit 1, sets status bit 7 and drops sckOe and mosiOe.
- R9: After a mode fault, control bit 1 stays 0 until software writes it to 1. With control bit 5 = 1, the select input has no effect in master mode.
- R10: In slave mode (bit 1 = 0), the block shifts on sckIn only while selIn is low, in mode 0 MSB first, and drives misoOut with misoOe high only while selected.
- R11: Raising selIn in slave mode mid-byte abandons the byte. No flag is set, the receive buffer is kept, and the next full byte is received correctly.
- R12: A data write taken in the same cycle as a master transfer completes counts as a collision. Both status bits 7 and 6 are set, and no new transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low reset |
| addr | input | 2 | register select |
| wrEn | input | 1 | register write strobe |
| rdEn | input | 1 | register read strobe |
| wrData | input | 8 | write data |
| rdData | output | 8 | read data for addr |
| sckIn | input | 1 | serial clock in (slave) |
| sckOut | output | 1 | serial clock out (master) |
| sckOe | output | 1 | serial clock drive enable |
| mosiIn | input | 1 | serial data in (slave) |
| mosiOut | output | 1 | serial data out (master) |
| mosiOe | output | 1 | mosi drive enable |
| misoIn | input | 1 | serial data in (master) |
| misoOut | output | 1 | serial data out (slave) |
| misoOe | output | 1 | miso drive enable |
| selIn | input | 1 | select input, active low |
| irq | output | 1 | interrupt request |

## Verification
Two things can land in one cycle: a software write to the data register and the final falling clock edge of a master transfer. The bench lines up a second data write so that it is taken on the exact edge where the divide-by-2 transfer ends. Both status flags must then read set, and the serial clock must stay idle. The byte that reached the slave model and the byte in the receive buffer must both be the ones from the first transfer.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  // control register bit positions (divider field starts at CTL_DIV)
  localparam int CTL_EN  = 0;
  localparam int CTL_MST = 1;
  localparam int CTL_IE  = 2;
  localparam int CTL_DIV = 3;
  // register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic load;     // copy write data into the shift register
    logic sample;   // hold the incoming serial bit
    logic shift;    // move the held bit into the register
    logic capture;  // last shift of the byte: fill the receive buffer
  } shiftStrobes_t;
endpackage

// File: rtl/spi_mf_datapath.sv
module spi_mf_datapath
  import spi_mf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobes_t     strobes,
  input  logic [DATA_W-1:0] loadByte,
  input  logic              serialIn,
  output logic              serialOut,
  output logic [DATA_W-1:0] rxBuf
);
  logic [DATA_W-1:0] shiftReg;
  logic              heldBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      heldBit  <= 1'b0;
      rxBuf    <= '0;
    end else begin
      if (strobes.sample) heldBit <= serialIn;
      if (strobes.load)
        shiftReg <= loadByte;
      else if (strobes.shift)
        shiftReg <= {shiftReg[DATA_W-2:0], heldBit};
      if (strobes.capture) rxBuf <= {shiftReg[DATA_W-2:0], heldBit};
    end
  end

  assign serialOut = shiftReg[DATA_W-1];

  AST_SHIFT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load || strobes.shift) |=> $stable(shiftReg)); // R4
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(rxBuf)); // R5
endmodule

// File: rtl/spi_mf_control.sv
module spi_mf_control
  import spi_mf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_SEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              selIn,
  output shiftStrobes_t     strobes,
  output logic              isMaster,
  output logic              slaveMosi,
  output logic [DATA_W-1:0] ctrlValue,
  output logic [DATA_W-1:0] statusValue,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOe,
  output logic              misoOe,
  output logic              irq
);
  localparam int CNT_W      = $clog2(DATA_W);
  localparam int HALF_W     = (1 << DIV_SEL_W) - 1;
  localparam int CTL_SELOUT = CTL_DIV + DIV_SEL_W;
  localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'((1 << (CTL_SELOUT + 1)) - 1);

  logic [DATA_W-1:0]    ctrlReg;
  logic [2:0]           sckSync;
  logic [1:0]           mosiSync, selSync;
  logic                 busy, sckReg, doneFlag, collFlag, armed;
  logic [HALF_W-1:0]    halfCnt, halfMax;
  logic [CNT_W-1:0]     bitCnt;
  logic [DIV_SEL_W-1:0] divSel;
  logic en, mst, ie, selOut, selLow, slaveActive, faultNow, mActive, tick, lastBit;
  logic dataWr, dataRd, statRd, xferBusy, loadOk, collideNow, clearNow;
  logic mSample, mShift, sSample, sShift;

  assign en      = ctrlReg[CTL_EN];
  assign mst     = ctrlReg[CTL_MST];
  assign ie      = ctrlReg[CTL_IE];
  assign divSel  = ctrlReg[CTL_DIV +: DIV_SEL_W];
  assign selOut  = ctrlReg[CTL_SELOUT];
  assign halfMax = HALF_W'((1 << divSel) - 1);
  assign selLow  = ~selSync[1];

  assign slaveActive = en & ~mst & selLow;
  assign faultNow    = en & mst & ~selOut & selLow;
  assign mActive     = en & mst & ~faultNow;
  assign tick        = mActive & busy & (halfCnt == halfMax);
  assign lastBit     = (bitCnt == CNT_W'(DATA_W - 1));

  assign dataWr     = wrEn & (addr == ADDR_DATA);
  assign dataRd     = rdEn & (addr == ADDR_DATA);
  assign statRd     = rdEn & (addr == ADDR_STAT);
  assign xferBusy   = busy | (slaveActive & (bitCnt != '0));
  assign loadOk     = dataWr & en & ~xferBusy & ~faultNow;
  assign collideNow = dataWr & xferBusy;
  assign clearNow   = armed & (dataWr | dataRd);

  assign mSample = tick & ~sckReg;
  assign mShift  = tick & sckReg;
  assign sSample = slaveActive & sckSync[1] & ~sckSync[2];
  assign sShift  = slaveActive & ~sckSync[1] & sckSync[2];

  always_comb begin
    strobes.load    = loadOk;
    strobes.sample  = mSample | sSample;
    strobes.shift   = mShift | sShift;
    strobes.capture = (mShift | sShift) & lastBit;
  end

  // input synchronisers for the slave side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      selSync  <= '1;
    end else begin
      sckSync  <= {sckSync[1:0], sckIn};
      mosiSync <= {mosiSync[0], mosiIn};
      selSync  <= {selSync[0], selIn};
    end
  end

  // control register: a mode fault overrides a same-cycle write of the master bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else begin
      if (wrEn && addr == ADDR_CTRL) ctrlReg <= wrData & CTL_MASK;
      if (faultNow) ctrlReg[CTL_MST] <= 1'b0;
    end
  end

  // clock generation and bit counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sckReg  <= 1'b0;
      halfCnt <= '0;
      bitCnt  <= '0;
    end else if (mActive) begin
      if (loadOk) begin
        busy    <= 1'b1;
        sckReg  <= 1'b0;
        halfCnt <= '0;
        bitCnt  <= '0;
      end else if (busy) begin
        if (tick) begin
          halfCnt <= '0;
          sckReg  <= ~sckReg;
          if (sckReg) begin
            bitCnt <= bitCnt + 1'b1;
            if (lastBit) busy <= 1'b0;
          end
        end else halfCnt <= halfCnt + 1'b1;
      end
    end else begin
      busy    <= 1'b0;
      sckReg  <= 1'b0;
      halfCnt <= '0;
      if (!slaveActive) bitCnt <= '0;
      else if (sShift) bitCnt <= bitCnt + 1'b1;
    end
  end

  // flags: setting wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      collFlag <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (strobes.capture || faultNow) doneFlag <= 1'b1;
      else if (clearNow) doneFlag <= 1'b0;
      if (collideNow) collFlag <= 1'b1;
      else if (clearNow) collFlag <= 1'b0;
      if (clearNow) armed <= 1'b0;
      else if (statRd && (doneFlag || collFlag)) armed <= 1'b1;
    end
  end

  assign isMaster    = mst;
  assign slaveMosi   = mosiSync[1];
  assign ctrlValue   = ctrlReg;
  assign statusValue = {doneFlag, collFlag, {(DATA_W-2){1'b0}}};
  assign sckOut      = sckReg;
  assign sckOe       = en & mst;
  assign mosiOe      = en & mst;
  assign misoOe      = slaveActive;
  assign irq         = doneFlag & ie;

  AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    faultNow |=> !ctrlReg[CTL_MST]); // R8
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(strobes.capture || faultNow)); // R6
  AST_MISO_NOT_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> !sckOe); // R10
  AST_COLLIDE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    collideNow |-> !strobes.load); // R4
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !sckReg || busy); // R2
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
  import spi_mf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_SEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              selIn,
  output logic              irq
);
  shiftStrobes_t     strobes;
  logic              isMaster, slaveMosi, serialOut;
  logic [DATA_W-1:0] ctrlValue, statusValue, rxBuf;

  spi_mf_control #(.DATA_W(DATA_W), .DIV_SEL_W(DIV_SEL_W)) u_control (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .sckIn(sckIn), .mosiIn(mosiIn), .selIn(selIn), .strobes(strobes),
    .isMaster(isMaster), .slaveMosi(slaveMosi), .ctrlValue(ctrlValue),
    .statusValue(statusValue), .sckOut(sckOut), .sckOe(sckOe), .mosiOe(mosiOe),
    .misoOe(misoOe), .irq(irq)
  );

  spi_mf_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadByte(wrData),
    .serialIn(isMaster ? misoIn : slaveMosi), .serialOut(serialOut), .rxBuf(rxBuf)
  );

  assign mosiOut = serialOut;
  assign misoOut = serialOut;

  always_comb begin
    case (addr)
      ADDR_CTRL: rdData = ctrlValue;
      ADDR_STAT: rdData = statusValue;
      ADDR_DATA: rdData = rxBuf;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: tb/test_spi_mf_ctrl.sv
module test_spi_mf_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = 8'h00, rdData;
  logic sckIn = 1'b0, mosiIn = 1'b0, selIn = 1'b1;
  logic sckOut, sckOe, mosiOut, mosiOe, misoIn, misoOut, misoOe, irq;

  spi_mf_ctrl i_spi_mf_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe), .mosiIn(mosiIn),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .misoIn(misoIn), .misoOut(misoOut),
    .misoOe(misoOe), .selIn(selIn), .irq(irq)
  );

  // slave model for master-mode tests: mode 0, MSB first
  logic [7:0] model = 8'h00;
  logic prevSck = 1'b0, capMosi = 1'b0;
  assign misoIn = model[7];
  always @(negedge clk) begin
    if (sckOut && !prevSck) capMosi = mosiOut;
    if (!sckOut && prevSck) model = {model[6:0], capMosi};
    prevSck = sckOut;
  end

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic clearFlags();
    logic [7:0] d;
    regRead(2'd1, d);
    regRead(2'd2, d);
  endtask

  task automatic waitIrq(output int cycles);
    cycles = 0;
    while (!irq && cycles < 2000) begin @(negedge clk); cycles++; end
  endtask

  task automatic masterXfer(input int dv, input logic [7:0] tx, input logic [7:0] slv,
                            output int cycles, output logic [7:0] rx);
    clearFlags();
    model = slv;
    regWrite(2'd0, 8'h07 | 8'(dv << 3));
    regWrite(2'd2, tx);
    waitIrq(cycles);
    repeat (3) @(negedge clk);
    regRead(2'd2, rx);
  endtask

  task automatic slaveBits(input logic [7:0] mo, input int n, output logic [7:0] mi);
    mi = 8'h00;
    for (int i = 0; i < n; i++) begin
      mosiIn = mo[7-i];
      repeat (4) @(negedge clk);
      mi = {mi[6:0], misoOut};
      sckIn = 1'b1;
      repeat (4) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    regRead(2'd0, d); chk("R1 control", d, 8'h00);
    regRead(2'd1, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 oe", {sckOe, mosiOe, misoOe, sckOut}, 4'b0000);
  endtask

  task automatic testMaster();
    int cyc; logic [7:0] rx, d;
    masterXfer(0, 8'hA5, 8'h3C, cyc, rx);
    chk("R3 div2 cycles", cyc, 16);
    chk("R2 slave got byte", model, 8'hA5);
    chk("R2 received byte", rx, 8'h3C);
    regRead(2'd1, d); chk("R6 done flag", d, 8'h80);
    chk("R6 irq on", irq, 1'b1);
    regWrite(2'd0, 8'h03);
    chk("R6 irq masked", irq, 1'b0);
  endtask

  task automatic testDividers();
    int cyc; logic [7:0] rx;
    for (int dv = 1; dv < 4; dv++) begin
      masterXfer(dv, 8'(8'h10 + dv), 8'(8'hC0 + dv), cyc, rx);
      chk("R3 divider cycles", cyc, 16 << dv);
      chk("R2 divider rx", rx, 8'(8'hC0 + dv));
    end
  endtask

  task automatic testCollision();
    int cyc; logic [7:0] d;
    clearFlags();
    model = 8'h69;
    regWrite(2'd0, 8'h17);
    regWrite(2'd2, 8'h96);
    repeat (10) @(negedge clk);
    regWrite(2'd2, 8'hFF);
    waitIrq(cyc);
    repeat (3) @(negedge clk);
    chk("R4 shifted byte intact", model, 8'h96);
    regRead(2'd1, d); chk("R4 collision flag", d, 8'hC0);
    clearFlags();
    regRead(2'd1, d); chk("R7 flags cleared", d, 8'h00);
    model = 8'h44;
    regWrite(2'd2, 8'h01);
    waitIrq(cyc);
    repeat (3) @(negedge clk);
    regRead(2'd2, d); chk("R5 rx after clear", d, 8'h44);
    regRead(2'd1, d); chk("R7 data read alone keeps flag", d, 8'h80);
  endtask

  task automatic testOverrun();
    int cyc; logic [7:0] d;
    clearFlags();
    model = 8'h11; regWrite(2'd2, 8'h00); waitIrq(cyc); repeat (3) @(negedge clk);
    model = 8'h22; regWrite(2'd2, 8'h00);
    repeat (200) @(negedge clk);
    regRead(2'd2, d); chk("R5 overwritten", d, 8'h22);
  endtask

  task automatic testSameCycle();
    logic [7:0] d; int highs;
    clearFlags();
    model = 8'hC3;
    regWrite(2'd0, 8'h07);
    regWrite(2'd2, 8'h5A);
    repeat (14) @(negedge clk);
    regWrite(2'd2, 8'hE7);
    highs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sckOut) highs++; end
    chk("R12 no new transfer", highs, 0);
    chk("R12 slave byte", model, 8'h5A);
    regRead(2'd1, d); chk("R12 both flags", d, 8'hC0);
    regRead(2'd2, d); chk("R12 rx byte", d, 8'hC3);
  endtask

  task automatic testFault();
    int cyc; logic [7:0] d;
    clearFlags();
    regWrite(2'd0, 8'h07);
    selIn = 1'b0; repeat (4) @(negedge clk);
    chk("R8 pins released", {sckOe, mosiOe}, 2'b00);
    regRead(2'd0, d); chk("R8 master cleared", d, 8'h05);
    regRead(2'd1, d); chk("R8 flag set", d, 8'h80);
    chk("R8 irq", irq, 1'b1);
    selIn = 1'b1; repeat (4) @(negedge clk);
    regRead(2'd0, d); chk("R9 stays slave", d, 8'h05);
    regWrite(2'd0, 8'h07);
    regRead(2'd0, d); chk("R9 software resets master", d, 8'h07);
    clearFlags();
    regWrite(2'd0, 8'h27);
    selIn = 1'b0; repeat (4) @(negedge clk);
    regRead(2'd0, d); chk("R9 select output ignored", d, 8'h27);
    model = 8'h0F;
    regWrite(2'd2, 8'hF0);
    waitIrq(cyc); repeat (3) @(negedge clk);
    regRead(2'd2, d); chk("R9 transfer with select low", d, 8'h0F);
    selIn = 1'b1;
  endtask

  task automatic testSlave();
    logic [7:0] d, mi;
    regWrite(2'd0, 8'h01);
    clearFlags();
    regWrite(2'd2, 8'h3C);
    repeat (4) @(negedge clk);
    chk("R10 miso off when deselected", misoOe, 1'b0);
    selIn = 1'b0; repeat (4) @(negedge clk);
    chk("R10 miso driven when selected", {misoOe, sckOe}, 2'b10);
    slaveBits(8'hA5, 8, mi);
    chk("R10 miso byte", mi, 8'h3C);
    regRead(2'd1, d); chk("R10 done flag", d, 8'h80);
    regRead(2'd2, d); chk("R10 mosi byte", d, 8'hA5);
    selIn = 1'b1; repeat (4) @(negedge clk);
    chk("R10 miso released", misoOe, 1'b0);
  endtask

  task automatic testAbort();
    logic [7:0] d, mi;
    clearFlags();
    regWrite(2'd2, 8'h77);
    selIn = 1'b0; repeat (4) @(negedge clk);
    slaveBits(8'hFF, 3, mi);
    selIn = 1'b1; repeat (4) @(negedge clk);
    regRead(2'd1, d); chk("R11 no flag on abort", d, 8'h00);
    regRead(2'd2, d); chk("R11 buffer kept", d, 8'hA5);
    regWrite(2'd2, 8'h81);
    selIn = 1'b0; repeat (4) @(negedge clk);
    slaveBits(8'h5A, 8, mi);
    chk("R11 miso after abort", mi, 8'h81);
    regRead(2'd1, d); chk("R11 flag after full byte", d, 8'h80);
    regRead(2'd2, d); chk("R11 mosi after abort", d, 8'h5A);
    selIn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMaster();
    testDividers();
    testCollision();
    testOverrun();
    testSameCycle();
    testFault();
    testSlave();
    testAbort();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule